// File: doc/BRIEF.md
# Command Stream Header Decoder

This block sits after a command word FIFO and turns its 32-bit words into individual method writes. A write is made of a subchannel id, a method byte address and a 32-bit data value. The decoder reads a header word, takes from it the opcode, the subchannel, the method and a word count, and then turns each of the following data words into one write. For an incrementing burst the method address advances by four bytes per word. For a non-incrementing burst the method address stays the same. An immediate header holds a small data value in its own bits, makes exactly one write and has no data words after it.

Two header layouts are supported. The static input `fmt_new` selects between them: 1 selects the newer layout with a 3-bit opcode field, and 0 selects the older layout with a single direction bit. Both the word input and the write output use valid/ready handshakes. An accepted word produces its write on the output register one cycle later. The input stalls while a write is waiting on the output.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the decoder clears `out_valid` and `err_flag`, drops any remaining burst count and returns to waiting for a header, so the first word accepted after reset is decoded as a header.
- R2: With `fmt_new`=1, a header whose bits 31:29 are 3'b001 is an incrementing burst. Its count N is bits 28:16, its subchannel is bits 15:13 and its method dword index is bits 12:0. The next N words produce writes at byte address (index<<2)+4*i, with i counted from 0.
- R3: With `fmt_new`=1, opcode 3'b011 is a non-incrementing burst with the same fields as R2, and all N of its data words are written to byte address index<<2.
- R4: With `fmt_new`=1, opcode 3'b100 makes exactly one write. Its data is header bits 28:16, zero-extended, and its address and subchannel come from the same fields as R2. The word that follows is decoded as a header.
- R5: With `fmt_new`=0, the count is bits 28:18 (11 bits), the subchannel is bits 15:13 and the method byte address is bits 12:0. Bit 30 clear selects an incrementing burst and bit 30 set selects a non-incrementing burst. Bits 17:16 are ignored.
- R6: An unknown header sets `err_flag`, which stays set until reset. Unknown means a newer-format opcode other than 001, 011 or 100, or an older-format header with bit 31 or bit 29 set. Such a header makes no write, and the word after it is decoded as a header.
- R7: An incrementing or non-incrementing header with count 0 makes no write, and the word after it is decoded as a header.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields hold their values. Every write is delivered exactly once and in order.
- R9: A write appears on the output in the cycle after the input handshake that caused it. Method byte addresses are 15 bits wide and wrap modulo 2^15 as a burst advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_new | input | 1 | Header layout select: 1 newer, 0 older (static) |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Decoder accepts the offered word |
| in_word | input | 32 | Command word (header or data) |
| out_valid | output | 1 | Method write present |
| out_ready | input | 1 | Consumer takes the method write |
| out_subch | output | 3 | Subchannel of the write |
| out_maddr | output | 15 | Method byte address of the write |
| out_data | output | 32 | Data value of the write |
| err_flag | output | 1 | Sticky unknown-header flag |

## Verification
The main hidden state is the header/data phase flag and the remaining count. If either is wrong, a data word is taken as a header or a header is taken as data. The first such word then shows at the ports as a wrong address, a missing write, an extra write or a spurious `err_flag`, one cycle after that word's handshake. A wrong address step shows on the second write of a burst. A fault in the output register shows under backpressure as a changed or lost write while `out_ready` is low. For this reason the stimulus table is replayed with a stalling consumer and the write stream is compared in order.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W    = 32;
  localparam int SUB_W     = 3;
  localparam int MIDX_W    = 13;
  localparam int MADDR_W   = MIDX_W + 2;
  localparam int NCNT_W    = 13;
  localparam int OCNT_W    = 11;
  localparam int CNT_W     = NCNT_W;
  localparam int IMM_W     = NCNT_W;
  localparam int SUB_LSB   = MIDX_W;
  localparam int NCNT_LSB  = SUB_LSB + SUB_W;
  localparam int OCNT_LSB  = NCNT_LSB + 2;
  localparam int OP_LSB    = NCNT_LSB + NCNT_W;

  typedef enum logic [1:0] {
    K_BAD = 2'd0,
    K_INC = 2'd1,
    K_FIX = 2'd2,
    K_IMM = 2'd3
  } hkind_e;

  typedef struct packed {
    hkind_e               kind;
    logic [SUB_W-1:0]     sub;
    logic [MADDR_W-1:0]   maddr;
    logic [CNT_W-1:0]     cnt;
    logic [WORD_W-1:0]    imm;
  } hdr_t;

  typedef struct packed {
    logic [SUB_W-1:0]     sub;
    logic [MADDR_W-1:0]   maddr;
    logic [WORD_W-1:0]    data;
  } mwr_t;

  // Newer layout: opcode | count | subchannel | dword index
  function automatic hdr_t unpack_new(logic [WORD_W-1:0] w);
    hdr_t h;
    h       = '0;
    h.sub   = w[SUB_LSB +: SUB_W];
    h.maddr = {w[MIDX_W-1:0], 2'b00};
    h.cnt   = w[NCNT_LSB +: NCNT_W];
    h.imm   = {{(WORD_W-IMM_W){1'b0}}, w[NCNT_LSB +: IMM_W]};
    case (w[OP_LSB +: 3])
      3'b001:  h.kind = K_INC;
      3'b011:  h.kind = K_FIX;
      3'b100:  h.kind = K_IMM;
      default: h.kind = K_BAD;
    endcase
    return h;
  endfunction

  // Older layout: direction bit 30 | count | subchannel | byte address
  function automatic hdr_t unpack_old(logic [WORD_W-1:0] w);
    hdr_t h;
    h       = '0;
    h.sub   = w[SUB_LSB +: SUB_W];
    h.maddr = {{(MADDR_W-MIDX_W){1'b0}}, w[MIDX_W-1:0]};
    h.cnt   = {{(CNT_W-OCNT_W){1'b0}}, w[OCNT_LSB +: OCNT_W]};
    if (w[31] || w[29])
      h.kind = K_BAD;
    else if (w[30])
      h.kind = K_FIX;
    else
      h.kind = K_INC;
    return h;
  endfunction

  function automatic logic [MADDR_W-1:0] step_addr(logic [MADDR_W-1:0] a, logic incr);
    return incr ? a + MADDR_W'(4) : a;
  endfunction
endpackage

// File: rtl/cmdp_hdr_unpack.sv
module cmdp_hdr_unpack
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              fmt_new,
  output hdr_t              hdr
);
  hdr_t hdr_n;
  hdr_t hdr_o;

  always_comb begin
    hdr_n = unpack_new(word);
    hdr_o = unpack_old(word);
    hdr   = fmt_new ? hdr_n : hdr_o;
  end
endmodule

// File: rtl/cmdp_burst_seq.sv
module cmdp_burst_seq
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_fire,
  input  logic [WORD_W-1:0] in_word,
  input  hdr_t              hdr,
  output logic              wr_evt,
  output mwr_t              wr,
  output logic              err
);
  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_e;

  phase_e             phase;
  logic [CNT_W-1:0]   remain;
  logic [MADDR_W-1:0] cur_addr;
  logic [SUB_W-1:0]   cur_sub;
  logic               cur_incr;
  logic               err_q;

  // named internal events
  logic hdr_fire, data_fire, bad_evt, imm_evt, open_evt, zero_evt, last_evt;
  logic is_burst;

  always_comb begin
    hdr_fire  = in_fire && (phase == PH_HDR);
    data_fire = in_fire && (phase == PH_DATA);
    is_burst  = (hdr.kind == K_INC) || (hdr.kind == K_FIX);
    bad_evt   = hdr_fire && (hdr.kind == K_BAD);
    imm_evt   = hdr_fire && (hdr.kind == K_IMM);
    open_evt  = hdr_fire && is_burst && (hdr.cnt != '0);
    zero_evt  = hdr_fire && is_burst && (hdr.cnt == '0);
    last_evt  = data_fire && (remain == CNT_W'(1));
  end

  always_comb begin
    wr_evt = imm_evt || data_fire;
    if (imm_evt) begin
      wr.sub   = hdr.sub;
      wr.maddr = hdr.maddr;
      wr.data  = hdr.imm;
    end else begin
      wr.sub   = cur_sub;
      wr.maddr = cur_addr;
      wr.data  = in_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_HDR;
      remain   <= '0;
      cur_addr <= '0;
      cur_sub  <= '0;
      cur_incr <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (open_evt) begin
        phase    <= PH_DATA;
        remain   <= hdr.cnt;
        cur_addr <= hdr.maddr;
        cur_sub  <= hdr.sub;
        cur_incr <= (hdr.kind == K_INC);
      end else if (data_fire) begin
        remain   <= remain - CNT_W'(1);
        cur_addr <= step_addr(cur_addr, cur_incr);
        if (last_evt)
          phase <= PH_HDR;
      end
      if (bad_evt)
        err_q <= 1'b1;
    end
  end

  assign err = err_q;

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    data_fire && cur_incr && !last_evt |=> cur_addr == $past(cur_addr) + MADDR_W'(4)); // R2
  AST_DATA_COUNT: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DATA |-> remain != '0); // R2
  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    data_fire && !cur_incr && !last_evt |=> cur_addr == $past(cur_addr)); // R3
  AST_IMM_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    imm_evt |=> phase == PH_HDR); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R6
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    bad_evt |=> phase == PH_HDR && err_q); // R6
  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> phase == PH_HDR); // R7
endmodule

// File: rtl/cmdp_out_reg.sv
module cmdp_out_reg
  import cmdp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  mwr_t wr_in,
  input  logic out_ready,
  output logic out_valid,
  output mwr_t wr_q,
  output logic can_take
);
  always_comb can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load)
      wr_q <= wr_in;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(wr_q)); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> (!out_valid || out_ready)); // R8
endmodule

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder
  import cmdp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fmt_new,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SUB_W-1:0]   out_subch,
  output logic [MADDR_W-1:0] out_maddr,
  output logic [WORD_W-1:0]  out_data,
  output logic               err_flag
);
  hdr_t hdr;
  mwr_t seq_wr;
  mwr_t held_wr;
  logic seq_wr_evt;
  logic can_take;
  logic in_fire;

  assign in_ready = can_take;
  assign in_fire  = in_valid && can_take;

  cmdp_hdr_unpack u_unpack (
    .word    (in_word),
    .fmt_new (fmt_new),
    .hdr     (hdr)
  );

  cmdp_burst_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .in_fire (in_fire),
    .in_word (in_word),
    .hdr     (hdr),
    .wr_evt  (seq_wr_evt),
    .wr      (seq_wr),
    .err     (err_flag)
  );

  cmdp_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (seq_wr_evt),
    .wr_in     (seq_wr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .wr_q      (held_wr),
    .can_take  (can_take)
  );

  assign out_subch = held_wr.sub;
  assign out_maddr = held_wr.maddr;
  assign out_data  = held_wr.data;

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
    seq_wr_evt |=> out_valid); // R9
  AST_READY_STALL: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |=> out_valid); // R8
endmodule

// File: tb/test_cmd_hdr_decoder.sv
module test_cmd_hdr_decoder;
  logic        clk = 1'b0;
  logic        rst, fmt_new, in_valid, in_ready, out_valid, out_ready, err_flag;
  logic [31:0] in_word, out_data;
  logic [2:0]  out_subch;
  logic [14:0] out_maddr;

  always #10 clk = ~clk;

  cmd_hdr_decoder i_cmd_hdr_decoder (
    .clk(clk), .rst(rst), .fmt_new(fmt_new), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready), .out_subch(out_subch),
    .out_maddr(out_maddr), .out_data(out_data), .err_flag(err_flag)
  );

  function automatic logic [31:0] nh(logic [2:0] op, logic [12:0] cnt, logic [2:0] sub, logic [12:0] idx);
    return {op, cnt, sub, idx};
  endfunction
  function automatic logic [31:0] oh(logic ni, logic [10:0] cnt, logic [2:0] sub, logic [12:0] ba, logic [1:0] junk);
    return {1'b0, ni, 1'b0, cnt, junk, sub, ba};
  endfunction

  localparam int NSTIM = 21;
  localparam int NEXP  = 14;
  localparam logic [32:0] STIM [NSTIM] = '{
    {1'b1, nh(3'b001, 13'd3, 3'd2, 13'h0010)},
    {1'b1, 32'hA000_0001}, {1'b1, 32'hA000_0002}, {1'b1, 32'hA000_0003},
    {1'b1, nh(3'b011, 13'd2, 3'd5, 13'h1FFF)},
    {1'b1, 32'h0000_00B1}, {1'b1, 32'h0000_00B2},
    {1'b1, nh(3'b100, 13'h1ABC, 3'd7, 13'h0005)},
    {1'b1, nh(3'b001, 13'd0, 3'd1, 13'h0003)},
    {1'b1, nh(3'b001, 13'd2, 3'd0, 13'h1FFF)},
    {1'b1, 32'h0000_00C1}, {1'b1, 32'h0000_00C2},
    {1'b0, oh(1'b0, 11'd2, 3'd3, 13'h0104, 2'b11)},
    {1'b0, 32'h0000_00D1}, {1'b0, 32'h0000_00D2},
    {1'b0, oh(1'b1, 11'd3, 3'd4, 13'h1ABC, 2'b00)},
    {1'b0, 32'h0000_00E1}, {1'b0, 32'h0000_00E2}, {1'b0, 32'h0000_00E3},
    {1'b0, oh(1'b0, 11'd0, 3'd6, 13'h0200, 2'b01)},
    {1'b1, nh(3'b100, 13'h1FFF, 3'd0, 13'h0000)}
  };
  localparam logic [49:0] EXPW [NEXP] = '{
    {3'd2, 15'h0040, 32'hA000_0001}, {3'd2, 15'h0044, 32'hA000_0002},
    {3'd2, 15'h0048, 32'hA000_0003},
    {3'd5, 15'h7FFC, 32'h0000_00B1}, {3'd5, 15'h7FFC, 32'h0000_00B2},
    {3'd7, 15'h0014, 32'h0000_1ABC},
    {3'd0, 15'h7FFC, 32'h0000_00C1}, {3'd0, 15'h0000, 32'h0000_00C2},
    {3'd3, 15'h0104, 32'h0000_00D1}, {3'd3, 15'h0108, 32'h0000_00D2},
    {3'd4, 15'h1ABC, 32'h0000_00E1}, {3'd4, 15'h1ABC, 32'h0000_00E2},
    {3'd4, 15'h1ABC, 32'h0000_00E3},
    {3'd0, 15'h0000, 32'h0000_1FFF}
  };

  function automatic string req_of(int k);
    case (k)
      0, 1, 2:    return "R2";
      3, 4:       return "R3";
      5, 13:      return "R4";
      6, 7:       return "R9";
      default:    return "R5";
    endcase
  endfunction

  int    checks = 0, fails = 0;
  bit    done = 0;
  logic [49:0] expq [0:63];
  string       exptag [0:63];
  int    exp_n = 0, exp_h = 0;
  bit    bp_en = 0;
  int    bp_cnt = 0;
  bit    prev_stall = 0;
  logic [49:0] prev_word;
  int    stall_bad = 0, rdy_bad = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [49:0] w, string tag);
    expq[exp_n]   = w;
    exptag[exp_n] = tag;
    exp_n++;
  endtask

  // called at a falling edge; returns at the falling edge after the handshake
  task automatic send(logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #1;
    bp_cnt++;
    out_ready = bp_en ? ((bp_cnt % 3) != 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (prev_stall && {out_subch, out_maddr, out_data} != prev_word) stall_bad++;
      if (!out_ready && in_ready) rdy_bad++;
      if (out_ready) begin
        if (exp_h >= exp_n) begin
          chk(1'b0, "R8", "unexpected write", 64'({out_subch, out_maddr, out_data}), 64'd0);
        end else begin
          chk({out_subch, out_maddr, out_data} == expq[exp_h], exptag[exp_h], "write",
              64'({out_subch, out_maddr, out_data}), 64'(expq[exp_h]));
          exp_h++;
        end
      end
      prev_stall = !out_ready;
      prev_word  = {out_subch, out_maddr, out_data};
    end else begin
      if (!rst && prev_stall) stall_bad++;
      prev_stall = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_word = '0; fmt_new = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(err_flag == 1'b0, "R1", "err_flag after reset", 64'(err_flag), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // table walk, consumer always ready (R2 R3 R4 R5 R7 R9)
    for (int k = 0; k < NEXP; k++) push(EXPW[k], req_of(k));
    for (int i = 0; i < NSTIM; i++) begin
      fmt_new = STIM[i][32];
      send(STIM[i][31:0]);
    end
    drain();
    chk(exp_h == exp_n, "R7", "all table writes seen", 64'(exp_h), 64'(exp_n));
    chk(err_flag == 1'b0, "R5", "no error on valid headers", 64'(err_flag), 64'd0);

    // same table under backpressure (R8)
    do_reset();
    bp_en = 1'b1;
    for (int k = 0; k < NEXP; k++) push(EXPW[k], "R8");
    for (int i = 0; i < NSTIM; i++) begin
      fmt_new = STIM[i][32];
      send(STIM[i][31:0]);
    end
    drain();
    bp_en = 1'b0;
    drain();
    chk(exp_h == exp_n, "R8", "no lost write under stall", 64'(exp_h), 64'(exp_n));
    chk(stall_bad == 0, "R8", "output held while stalled", 64'(stall_bad), 64'd0);
    chk(rdy_bad == 0, "R8", "in_ready low while stalled", 64'(rdy_bad), 64'd0);

    // R9: one-cycle latency
    fmt_new = 1'b1;
    push({3'd1, 15'h0004, 32'h0000_0042}, "R9");
    send(nh(3'b100, 13'h0042, 3'd1, 13'h0001));
    chk(out_valid == 1'b1, "R9", "write one cycle after accept", 64'(out_valid), 64'd1);
    drain();

    // R1: reset in the middle of a burst
    push({3'd1, 15'h0020, 32'h1111_1111}, "R2");
    send(nh(3'b001, 13'd5, 3'd1, 13'h0008));
    send(32'h1111_1111);
    drain();
    do_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after mid-burst reset", 64'(out_valid), 64'd0);
    push({3'd3, 15'h0008, 32'h0000_0055}, "R1");
    send(nh(3'b100, 13'h0055, 3'd3, 13'h0002));
    drain();
    chk(exp_h == exp_n, "R1", "header decoded after reset", 64'(exp_h), 64'(exp_n));

    // R6: unknown opcode, sticky flag, next word is a header
    send(32'h0003_1234);
    chk(err_flag == 1'b1, "R6", "err after opcode 000", 64'(err_flag), 64'd1);
    push({3'd6, 15'h0030, 32'h0000_0007}, "R6");
    send(nh(3'b100, 13'h0007, 3'd6, 13'h000C));
    drain();
    chk(exp_h == exp_n, "R6", "word after bad header is a header", 64'(exp_h), 64'(exp_n));
    chk(err_flag == 1'b1, "R6", "err stays set", 64'(err_flag), 64'd1);
    do_reset();
    chk(err_flag == 1'b0, "R1", "err cleared by reset", 64'(err_flag), 64'd0);
    send(32'hE000_0000);
    drain();
    chk(err_flag == 1'b1, "R6", "err after opcode 111", 64'(err_flag), 64'd1);
    do_reset();

    // R6 with older layout: bit 31 or bit 29 set
    fmt_new = 1'b0;
    send(32'h8004_0004);
    drain();
    chk(err_flag == 1'b1, "R6", "older layout bit31", 64'(err_flag), 64'd1);
    do_reset();
    send(32'h2004_0004);
    drain();
    chk(err_flag == 1'b1, "R6", "older layout bit29", 64'(err_flag), 64'd1);
    chk(exp_h == exp_n, "R6", "no write from bad headers", 64'(exp_h), 64'(exp_n));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule